// File: doc/BRIEF.md
# DRAM Refresh Sequencer with Page-Cache Invalidation

This block keeps a page-mode DRAM array refreshed. An internal interval timer raises a refresh request at a fixed period. The block holds that request pending until the processor bus is idle. It then raises a refresh acknowledge, which the surrounding controller uses to suppress normal access RAS and the data acknowledge. While the acknowledge is high, the block runs a CAS-before-RAS sequence. A precharge wait comes first. The refresh CAS follows, and then the refresh RAS is driven to every bank at once.

Refresh leaves the open row of each bank closed. For that reason the block also owns the page-invalid flag read by the access RAS logic. The flag is set by reset and by every refresh. It is cleared only when a bus cycle completes outside refresh. As a result, the first access after an invalidation is run as a full non-page cycle, with RAS held for the whole cycle. The flag is registered and changes only between bus cycles, or while the acknowledge holds memory accesses off.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `rfsh_ack`, `rfsh_cas` and all `rfsh_ras` bits low and `page_invalid` high. This holds even when reset arrives in the middle of a refresh.
- R2: A refresh request is raised every `INTERVAL_CLKS` clocks and stays pending until it is granted. With the bus idle, consecutive rising edges of `rfsh_ack` are exactly `INTERVAL_CLKS` cycles apart.
- R3: A pending request is granted only at a clock edge where `bus_strobe` is low, and `rfsh_ack` rises in the following cycle. While `bus_strobe` stays high, `rfsh_ack` stays low.
- R4: Once raised, `rfsh_ack` stays high for exactly `PRE_CLKS + RAS_CLKS + 4` cycles.
- R5: After `rfsh_ack` rises, `rfsh_cas` and `rfsh_ras` stay low for `PRE_CLKS + 1` cycles, which is the precharge time.
- R6: `rfsh_cas` rises one cycle before `rfsh_ras` and stays high until the cycle in which `rfsh_ras` falls.
- R7: All `NBANK` bits of `rfsh_ras` are high together for exactly `RAS_CLKS` cycles per refresh, independent of any address.
- R8: `page_invalid` becomes high in the last cycle of the acknowledge window and is high when `rfsh_ack` falls.
- R9: `page_invalid` is cleared in the cycle after a clock edge at which `bus_strobe` is seen low after being high, provided `rfsh_ack` is low. The flag never changes while `bus_strobe` is high and `rfsh_ack` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low global reset |
| bus_strobe | input | 1 | Processor address strobe, 1 = bus cycle in progress |
| rfsh_ack | output | 1 | Refresh acknowledge; suppresses access RAS and data acknowledge |
| rfsh_cas | output | 1 | Refresh CAS strobe, active high |
| rfsh_ras | output | NBANK | Refresh RAS strobe for each bank, active high |
| page_invalid | output | 1 | Open-page latch invalid, registered |

## Verification
The bench builds the block with `INTERVAL_CLKS` = 60, `PRE_CLKS` = 2, `RAS_CLKS` = 3 and `NBANK` = 4. A 60-clock period puts several refreshes, and a strobe held longer than a full interval, within a few hundred cycles. The unequal precharge and RAS dwell lengths make an off-by-one or a swapped counter load show up as a shifted CAS or RAS edge. Four banks let the bench confirm that every RAS bit moves together.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
// Shared types for the refresh sequencer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package rfsh_pkg;

    // One-hot sequencer states, in the order a refresh visits them.
    typedef enum logic [6:0] {
        ST_IDLE = 7'b000_0001,
        ST_ACK  = 7'b000_0010,
        ST_PRE  = 7'b000_0100,
        ST_CAS  = 7'b000_1000,
        ST_RAS  = 7'b001_0000,
        ST_REL  = 7'b010_0000,
        ST_INV  = 7'b100_0000
    } rfsh_state_e;

endpackage

// File: rtl/rfsh_timer.sv
`timescale 1ns/1ps
// Refresh interval timer.
// Counts INTERVAL_CLKS clocks per period and raises a request at the end of
// each period. The request stays pending until the sequencer grants it.
// Assumes: INTERVAL_CLKS >= 2, grant_i is a single-cycle pulse.
module rfsh_timer #(
    parameter int unsigned INTERVAL_CLKS = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    output logic req_o
);
    localparam int unsigned CW = $clog2(INTERVAL_CLKS);

    logic [CW-1:0] tick_cnt;
    logic          period_end;

    assign period_end = (tick_cnt == CW'(INTERVAL_CLKS - 1));

    // Free-running period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          tick_cnt <= '0;
        else if (period_end) tick_cnt <= '0;
        else                 tick_cnt <= tick_cnt + 1'b1;
    end

    // Pending request: a new period end wins over a grant in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          req_o <= 1'b0;
        else if (period_end) req_o <= 1'b1;
        else if (grant_i)    req_o <= 1'b0;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !grant_i) |=> req_o); // R2

endmodule

// File: rtl/rfsh_fsm.sv
`timescale 1ns/1ps
// Refresh sequencer state machine.
// Grants a pending request only while the bus strobe is low. It then walks
// ACK, PRE (PRE_CLKS), CAS, RAS (RAS_CLKS), REL and INV. A single dwell
// counter times both waits.
// Assumes: PRE_CLKS >= 1, RAS_CLKS >= 1; the access RAS logic drops its RAS
// when the acknowledge rises, so precharge is counted from that point.
module rfsh_fsm
    import rfsh_pkg::*;
#(
    parameter int unsigned PRE_CLKS = 3,
    parameter int unsigned RAS_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic bus_strobe_i,
    output logic grant_o,
    output logic ack_o,
    output logic cas_o,
    output logic ras_o,
    output logic inv_set_o
);
    localparam int unsigned MAXD = (PRE_CLKS > RAS_CLKS) ? PRE_CLKS : RAS_CLKS;
    localparam int unsigned DW   = $clog2(MAXD + 1);
    localparam int unsigned GW   = $clog2(PRE_CLKS + 5);

    rfsh_state_e   state, state_nx;
    logic [DW-1:0] dwell, dwell_nx;

    assign grant_o = (state == ST_IDLE) && req_i && !bus_strobe_i;

    // Next-state and dwell counter logic.
    always_comb begin
        state_nx = state;
        dwell_nx = dwell;
        unique case (state)
            ST_IDLE: if (grant_o) state_nx = ST_ACK;
            ST_ACK: begin
                state_nx = ST_PRE;
                dwell_nx = DW'(PRE_CLKS - 1);
            end
            ST_PRE: begin
                if (dwell == '0) state_nx = ST_CAS;
                else             dwell_nx = dwell - 1'b1;
            end
            ST_CAS: begin
                state_nx = ST_RAS;
                dwell_nx = DW'(RAS_CLKS - 1);
            end
            ST_RAS: begin
                if (dwell == '0) state_nx = ST_REL;
                else             dwell_nx = dwell - 1'b1;
            end
            ST_REL:  state_nx = ST_INV;
            ST_INV:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State and dwell registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            dwell <= '0;
        end else begin
            state <= state_nx;
            dwell <= dwell_nx;
        end
    end

    assign ack_o     = (state != ST_IDLE);
    assign cas_o     = (state == ST_CAS) || (state == ST_RAS);
    assign ras_o     = (state == ST_RAS);
    assign inv_set_o = (state == ST_REL);

    // Checker counter: cycles spent acknowledged with CAS low since ack rose.
    logic [GW-1:0] gap_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || !ack_o)  gap_cnt <= '0;
        else if (!cas_o)       gap_cnt <= gap_cnt + 1'b1;
    end

    AST_GRANT_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> !$past(bus_strobe_i)); // R3
    AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_o) |-> (gap_cnt >= GW'(PRE_CLKS + 1))); // R5
    AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_o) |-> $past(cas_o)); // R6
    AST_CAS_SPANS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        ras_o |-> cas_o); // R6

endmodule

// File: rtl/page_flag.sv
`timescale 1ns/1ps
// Page-invalid flag register.
// Set by reset and by the sequencer's release state. Cleared when a bus
// cycle ends (strobe seen high, then low) while no refresh is acknowledged.
// Assumes: bus_strobe is synchronous to clk.
module page_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    input  logic strobe_i,
    output logic invalid_o
);
    logic strobe_q;

    // Previous strobe sample, used to find the end of a bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_i;
    end

    // Flag update: refresh sets, a completed access outside refresh clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                                invalid_o <= 1'b1;
        else if (set_i)                            invalid_o <= 1'b1;
        else if (!ack_i && strobe_q && !strobe_i)  invalid_o <= 1'b0;
    end

    AST_FLAG_BETWEEN_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(invalid_o) |-> ($past(ack_i) || !$past(strobe_i))); // R9

endmodule

// File: rtl/dram_refresh_seq.sv
`timescale 1ns/1ps
// DRAM CAS-before-RAS refresh sequencer, top level.
// Ties the interval timer, the sequencer and the page-invalid flag together
// and fans the refresh RAS out to every bank.
// Assumes: the access RAS logic honours rfsh_ack and page_invalid.
module dram_refresh_seq #(
    parameter int unsigned INTERVAL_CLKS = 3120,
    parameter int unsigned PRE_CLKS      = 3,
    parameter int unsigned RAS_CLKS      = 4,
    parameter int unsigned NBANK         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_strobe,
    output logic             rfsh_ack,
    output logic             rfsh_cas,
    output logic [NBANK-1:0] rfsh_ras,
    output logic             page_invalid
);
    logic req, grant, ras_all, inv_set;

    rfsh_timer #(.INTERVAL_CLKS(INTERVAL_CLKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant_i (grant),
        .req_o   (req)
    );

    rfsh_fsm #(.PRE_CLKS(PRE_CLKS), .RAS_CLKS(RAS_CLKS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .bus_strobe_i (bus_strobe),
        .grant_o      (grant),
        .ack_o        (rfsh_ack),
        .cas_o        (rfsh_cas),
        .ras_o        (ras_all),
        .inv_set_o    (inv_set)
    );

    page_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (inv_set),
        .ack_i     (rfsh_ack),
        .strobe_i  (bus_strobe),
        .invalid_o (page_invalid)
    );

    // Every bank receives the same refresh RAS.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        assign rfsh_ras[g] = ras_all;
    end

    AST_INVALID_AT_ACK_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rfsh_ack) |-> page_invalid); // R8
    AST_ACK_COVERS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_ras != '0) |-> rfsh_ack); // R4

endmodule

// File: tb/dram_refresh_seq_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module dram_refresh_seq_bench;
    localparam int unsigned INTERVAL = 60;
    localparam int unsigned PRE      = 2;
    localparam int unsigned RASN     = 3;
    localparam int unsigned NB       = 4;
    localparam int unsigned ACKLEN   = PRE + RASN + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_strobe = 1'b0;
    logic          rfsh_ack, rfsh_cas, page_invalid;
    logic [NB-1:0] rfsh_ras;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_rise = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dram_refresh_seq #(
        .INTERVAL_CLKS(INTERVAL), .PRE_CLKS(PRE), .RAS_CLKS(RASN), .NBANK(NB)
    ) u_dram_refresh_seq (
        .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe),
        .rfsh_ack(rfsh_ack), .rfsh_cas(rfsh_cas), .rfsh_ras(rfsh_ras),
        .page_invalid(page_invalid)
    );

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_rise();
        int n = 0;
        while (!rfsh_ack && n < 300) begin
            tick();
            n++;
        end
        chk(rfsh_ack, "R2", "ack rises within limit", rfsh_ack, 1);
    endtask

    task automatic wait_fall();
        int n = 0;
        while (rfsh_ack && n < 50) begin
            tick();
            n++;
        end
        chk(!rfsh_ack, "R4", "ack falls within limit", rfsh_ack, 0);
    endtask

    // R1: reset state.
    task automatic t_reset();
        chk(!rfsh_ack, "R1", "reset ack", rfsh_ack, 0);
        chk(!rfsh_cas, "R1", "reset cas", rfsh_cas, 0);
        chk(rfsh_ras == '0, "R1", "reset ras", rfsh_ras, 0);
        chk(page_invalid, "R1", "reset page_invalid", page_invalid, 1);
    endtask

    // R9: a completed access clears the flag, never mid-cycle.
    task automatic t_access_clears();
        bus_strobe = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(page_invalid, "R9", "flag held during first access", page_invalid, 1);
        end
        bus_strobe = 1'b0;
        chk(page_invalid, "R9", "flag at strobe drop", page_invalid, 1);
        tick();
        chk(!page_invalid, "R9", "flag cleared after cycle end", page_invalid, 0);
    endtask

    // R4-R8: cycle-by-cycle shape of one refresh.
    task automatic t_refresh_shape();
        wait_rise();
        last_rise = cyc;
        for (int i = 0; i <= int'(ACKLEN); i++) begin
            bit e_ack = (i < int'(ACKLEN));
            bit e_cas = (i >= int'(PRE) + 1) && (i <= int'(PRE + RASN) + 1);
            bit e_ras = (i >= int'(PRE) + 2) && (i <= int'(PRE + RASN) + 1);
            bit e_inv = (i >= int'(PRE + RASN) + 3);
            chk(rfsh_ack == e_ack, "R4", $sformatf("ack at step %0d", i), rfsh_ack, e_ack);
            chk(rfsh_cas == e_cas, "R6", $sformatf("cas at step %0d", i), rfsh_cas, e_cas);
            chk(rfsh_ras == {NB{e_ras}}, "R7", $sformatf("ras at step %0d", i),
                rfsh_ras, {NB{e_ras}});
            if (i <= int'(PRE))
                chk(!rfsh_cas && rfsh_ras == '0, "R5",
                    $sformatf("precharge quiet at step %0d", i), rfsh_cas, 0);
            chk(page_invalid == e_inv, "R8", $sformatf("flag at step %0d", i),
                page_invalid, e_inv);
            tick();
        end
    endtask

    // R2: period between refreshes with the bus idle.
    task automatic t_interval();
        wait_rise();
        chk(cyc - last_rise == int'(INTERVAL), "R2", "refresh period",
            cyc - last_rise, INTERVAL);
        last_rise = cyc;
        wait_fall();
    endtask

    // R3, R9: a strobe held past the period postpones the grant.
    task automatic t_hold_off();
        bus_strobe = 1'b1;
        for (int i = 0; i < int'(INTERVAL) + 10; i++) begin
            tick();
            chk(!rfsh_ack, "R3", "no grant while strobe high", rfsh_ack, 0);
            chk(page_invalid, "R9", "flag stable while strobe high", page_invalid, 1);
        end
        bus_strobe = 1'b0;
        tick();
        chk(rfsh_ack, "R3", "grant after strobe drops", rfsh_ack, 1);
        chk(!page_invalid, "R9", "flag cleared by postponed cycle end", page_invalid, 0);
        wait_fall();
        chk(page_invalid, "R8", "flag set after postponed refresh", page_invalid, 1);
    endtask

    // R1: reset during refresh RAS drops every strobe.
    task automatic t_reset_mid();
        wait_rise();
        for (int i = 0; i < int'(PRE) + 2; i++) tick();
        chk(rfsh_ras == '1, "R7", "ras active before reset", rfsh_ras, '1);
        rst_n = 1'b0;
        tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        chk(!rfsh_ack && rfsh_ras == '0, "R1", "quiet after reset release", rfsh_ack, 0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_access_clears();
        t_refresh_shape();
        t_interval();
        t_hold_off();
        t_reset_mid();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule